// File: doc/BRIEF.md
# Periodic 16-bit Reload Down-Counter Timer

This block is a small timer peripheral behind a 32-bit word register port. Software loads a 16-bit reload value, then sets an enable bit in a control register. From then on the counter steps down by one on every tick of a fixed time base, and returns to the reload value each time it passes through zero. A free-running prescaler divides the system clock by a parameter (50 by default, for 1 MHz ticks from 50 MHz). Each expiry gives a one-cycle pulse on an output that an interrupt source can consume.

The control register also carries a self-clearing reset bit. A control write with that bit set stops the counter and zeroes the control, reload and count state; the rest of that write is thrown away. Clearing the enable bit never stops a running counter: only the reset bit or the block reset do that. The count register can be read but not written.

Top module: `tmr16_reload`

## Requirements
- R1: After rst_ni is released, the control, reload and count registers read 0, expire_o is low, and the counter is stopped.
- R2: The prescaler raises a tick once every DIV clocks. A running counter changes value only on a tick, so expiries with a zero reload come exactly DIV clocks apart.
- R3: A write to offset 0x00 with bit 31 clear stores all 32 written bits, readable at 0x00 from the next cycle. If bit 0 is also set, the counter starts running.
- R4: A control write with bit 0 clear does not stop a counter that is already running.
- R5: A control write with bit 31 set stops the counter and clears control, reload and count to 0. None of the written bits are stored.
- R6: A write to offset 0x08 keeps bits 15:0 as the reload value, which reads back zero-extended. It also loads the count with that value at the same clock edge.
- R7: A read of offset 0x0C returns the current count, zero-extended. Writes to 0x0C change nothing.
- R8: On a tick while running with the count at 0, the count takes the reload value, and expire_o is high for exactly the next cycle.
- R9: With a reload value of 0, the running count stays at 0 and expire_o pulses once per tick.
- R10: Reads of any offset other than 0x00, 0x08 or 0x0C return 0, and writes there are ignored. rdata_o is 0 when no read is requested.
- R11: A reload write in the same cycle as a tick takes priority. The count takes the written value, and no expiry pulse is produced for that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset within the 0x100 window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| expire_o | output | 1 | One-cycle pulse after each expiry |

## Verification
A bad count value, such as a missed decrement or a wrong reload, is visible on the next read of offset 0x0C. The bench reads that offset on every idle cycle, so such an error shows up within one clock of the faulty edge. A bad run flag or prescaler phase moves the cycle on which expire_o rises, and a cycle-by-cycle comparison catches this on the very first pulse. A clear or store error in the control path shows up on the readback that immediately follows the write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_RELOAD = 8'h08;
  localparam logic [7:0] OFS_COUNT  = 8'h0C;
  localparam int unsigned CTRL_RST_BIT = 31;
  localparam int unsigned CTRL_EN_BIT  = 0;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  generate
    if (DIV > 1) begin : g_div
      logic [PH_W-1:0] ph_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             ph_q <= '0;
        else if (ph_q == PH_LAST) ph_q <= '0;
        else                     ph_q <= ph_q + 1'b1;
      end
      assign tick_o = (ph_q == PH_LAST);

      AST_TICK_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R2
    end else begin : g_pass
      assign tick_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]  reload_o,
  output logic              clr_o,
  output logic              start_o,
  output logic              load_o,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = WORD_W - CNT_W;

  logic              wr, rd, sel_ctrl, sel_rel, sel_cnt;
  logic [WORD_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  reload_q;

  assign wr       = req_i & we_i;
  assign rd       = req_i & ~we_i;
  assign sel_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
  assign sel_rel  = (addr_i == ADDR_W'(OFS_RELOAD));
  assign sel_cnt  = (addr_i == ADDR_W'(OFS_COUNT));

  assign clr_o   = wr & sel_ctrl & wdata_i[CTRL_RST_BIT];
  assign start_o = wr & sel_ctrl & ~wdata_i[CTRL_RST_BIT] & wdata_i[CTRL_EN_BIT];
  assign load_o  = wr & sel_rel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (clr_o) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (wr && sel_ctrl) ctrl_q   <= wdata_i;
      if (load_o)         reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (sel_ctrl)     rdata_o = ctrl_q;
      else if (sel_rel) rdata_o = {{PAD_W{1'b0}}, reload_q};
      else if (sel_cnt) rdata_o = {{PAD_W{1'b0}}, cnt_i};
    end
  end

  assign reload_o = reload_q;

  AST_RST_WIPES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> (ctrl_q == '0) && (reload_q == '0)); // R5
  AST_CTRL_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel_ctrl && !wdata_i[CTRL_RST_BIT]) |=> ctrl_q == $past(wdata_i)); // R3
  AST_RELOAD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> reload_q == $past(wdata_i[CNT_W-1:0])); // R6
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, exp_q, at_zero, step;

  assign at_zero = (cnt_q == '0);
  assign step    = tick_i & run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= step & at_zero & ~load_i;
      if (start_i) run_q <= 1'b1;
      if (load_i)    cnt_q <= load_val_i;
      else if (step) cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign run_o    = run_q;
  assign expire_o = exp_q;

  AST_STOP_ON_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !run_o && (cnt_o == '0) && !expire_o); // R5
  AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !clr_i) |=> run_o); // R4
  AST_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_o && cnt_o != '0 && !load_i && !clr_i) |=> cnt_o == $past(cnt_o) - CNT_W'(1)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !clr_i) |=> $stable(cnt_o)); // R2
  AST_EXPIRE_AT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> cnt_o == reload_i); // R8
  AST_ZERO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && reload_i == '0) |-> cnt_o == '0); // R9
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (cnt_o == $past(load_val_i)) && !expire_o); // R11
endmodule

// File: rtl/tmr16_reload.sv
module tmr16_reload
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DIV    = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              expire_o
);
  logic             tick, clr, start, load, run;
  logic [CNT_W-1:0] cnt, reload;

  tmr_prescaler #(.DIV(DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  tmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .cnt_i(cnt), .reload_o(reload),
    .clr_o(clr), .start_o(start), .load_o(load), .rdata_o(rdata_o)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .clr_i(clr),
    .start_i(start), .load_i(load), .load_val_i(wdata_i[CNT_W-1:0]),
    .reload_i(reload), .cnt_o(cnt), .run_o(run), .expire_o(expire_o)
  );

  AST_EXPIRE_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> $past(run)); // R8
endmodule

// File: tb/tb_tmr16_reload.sv
`timescale 1ns/1ps
module tb_tmr16_reload;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        expire;

  tmr16_reload #(.ADDR_W(8), .CNT_W(16), .DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .expire_o(expire)
  );

  int    n_vec = 0, n_bad = 0, cyc = 0, last_exp = -1;
  string tag = "R1";
  bit    done = 1'b0;

  // reference state built from the requirements
  logic [31:0] m_ctrl;
  logic [15:0] m_rel, m_cnt;
  logic        m_run, m_exp;
  int          m_ph;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_rel <= '0; m_cnt <= '0; m_run <= 1'b0; m_exp <= 1'b0; m_ph <= 0;
    end else begin
      bit tk, wr, clr, ld;
      tk  = (m_ph == DIV - 1);
      wr  = req && we;
      clr = wr && addr == 8'h00 && wdata[31];
      ld  = wr && addr == 8'h08;
      m_ph <= tk ? 0 : m_ph + 1;
      cyc  <= cyc + 1;
      if (clr) begin
        m_ctrl <= '0; m_rel <= '0; m_cnt <= '0; m_run <= 1'b0; m_exp <= 1'b0;
      end else begin
        m_exp <= tk && m_run && m_cnt == 0 && !ld;
        if (wr && addr == 8'h00) begin
          m_ctrl <= wdata;
          if (wdata[0]) m_run <= 1'b1;
        end
        if (ld) begin
          m_rel <= wdata[15:0];
          m_cnt <= wdata[15:0];
        end else if (tk && m_run) begin
          m_cnt <= (m_cnt == 0) ? m_rel : m_cnt - 16'd1;
        end
      end
    end
  end

  function automatic logic [31:0] exp_rd();
    if (!(req && !we)) return 32'h0;        // R10
    case (addr)
      8'h00:   return m_ctrl;
      8'h08:   return {16'h0, m_rel};
      8'h0C:   return {16'h0, m_cnt};
      default: return 32'h0;                // R10
    endcase
  endfunction

  task automatic check_cycle();
    logic [31:0] e;
    e = exp_rd();
    n_vec++;
    if (rdata !== e) begin
      n_bad++;
      $display("FAIL %s: rdata addr=%h actual=%h expected=%h", tag, addr, rdata, e);
    end
    n_vec++;
    if (expire !== m_exp) begin
      n_bad++;
      $display("FAIL %s: expire_o actual=%b expected=%b cyc=%0d", tag, expire, m_exp, cyc);
    end
    if (expire === 1'b1) begin
      if (tag == "R9" && last_exp >= 0) begin
        n_vec++;
        if (cyc - last_exp != DIV) begin
          n_bad++;
          $display("FAIL R2: expiry gap actual=%0d expected=%0d", cyc - last_exp, DIV);
        end
      end
      last_exp = cyc;
    end
  endtask

  initial forever begin
    @(negedge clk); #1;
    if (rst_n && !done) check_cycle();
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
  endtask
  task automatic rd(input logic [7:0] a);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a; wdata = '0;
  endtask
  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk); req = 1'b1; we = 1'b0; addr = 8'h0C; wdata = '0;
    end
  endtask
  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #50000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    rd(8'h00); rd(8'h08); rd(8'h0C);
    @(negedge clk); req = 1'b0; we = 1'b0; addr = 8'h00;   // R10 no request
    idle(2 * DIV);

    tag = "R6";
    wr(8'h08, 32'hABC1_2345);
    rd(8'h08); rd(8'h0C);

    tag = "R3";
    wr(8'h00, 32'h5A5A_0001);
    rd(8'h00);
    idle(5 * DIV);

    tag = "R4";
    wr(8'h00, 32'h0000_00F0);
    rd(8'h00);
    idle(4 * DIV);

    tag = "R7";
    for (int k = 0; k < DIV; k++) begin
      wr(8'h0C, 32'h0000_FFFF - k);
      idle(1);
    end

    tag = "R10";
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h10, 32'h8000_0000); wr(8'hFC, 32'h1234_5678);
    wr(8'h01, 32'h8000_0001); wr(8'h09, 32'h0000_0001);
    rd(8'h04); rd(8'h10); rd(8'hFC); rd(8'h0D); rd(8'h00); rd(8'h08);
    idle(2);

    tag = "R5";
    wr(8'h00, 32'h8000_00FF);
    rd(8'h00); rd(8'h08); rd(8'h0C);
    idle(3 * DIV);

    tag = "R8";
    wr(8'h08, 32'd3);
    wr(8'h00, 32'h1);
    idle(12 * DIV);

    tag = "R9";
    last_exp = -1;
    wr(8'h08, 32'd0);
    idle(10 * DIV);

    tag = "R11";
    for (int k = 0; k < 3 * DIV; k++) begin
      wr(8'h08, (k % 3 == 0) ? 32'd0 : 32'd100 + k);
      idle(1 + (k % 3));
    end

    tag = "R8";
    for (int r = 0; r < 8; r++) begin
      wr(8'h00, 32'h8000_0000);
      wr(8'h08, r);
      idle(r % DIV);
      wr(8'h00, 32'h0000_0001);
      idle(6 * DIV + r);
    end

    tag = "R5";
    wr(8'h00, 32'h8000_0001);
    idle(2 * DIV);
    rd(8'h00);

    @(negedge clk); req = 1'b0;
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule